// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 4096 words by 4 bits. The RAM has one data bus that carries both written and read data. The host hands over one word-sized read or write at a time through a valid/ready handshake. The sequencer then walks the RAM strobes through a fixed series of phases, each a whole number of clock cycles long: address and chip-enable setup, the write pulse or read access, a hold cycle, and a bus turnaround with the chip deselected.

Every strobe on the memory side is active-low. The block drives the write data onto the shared bus through a separate output-enable, so a pad or a bench can build the tri-state buffer. Read data comes back to the host on a register together with a one-cycle valid pulse. When no request is pending, the chip stays deselected and nothing drives the bus.

Top module: `sram_seq`

## Requirements
- R1: While reset is asserted, and whenever the block is idle, chip enable, write enable and output enable are all high, the data driver enable is low, ready is high and the response valid is low.
- R2: A request is taken on a rising clock edge where both valid and ready are high. Ready then stays low for T_ADDR + T_WP + 1 + T_TURN cycles after a write, or for T_ADDR + T_ACC + 1 + T_TURN cycles after a read. It returns high in the cycle after that.
- R3: The memory address equals the accepted request address in every cycle in which chip enable is low, and it does not change while chip enable stays low.
- R4: A write keeps chip enable low with write enable high for T_ADDR cycles. It then holds write enable low for exactly T_WP cycles, with output enable high. Write enable is never low while chip enable is high.
- R5: On a write, the data driver enable is high and the driven value equals the write data from the first setup cycle through the one cycle after write enable rises. The driver is never enabled during a read.
- R6: A read keeps chip enable low with output enable high for T_ADDR cycles. It then holds output enable low with write enable high for exactly T_ACC cycles, and captures the bus on the last of those cycles. The response valid is high for exactly one cycle, the cycle after the access, carrying that value. A write produces no response pulse.
- R7: After the hold cycle, chip enable is high and no side drives the bus for T_TURN cycles. Output enable low and the data driver enable high never occur in the same cycle. Output enable never falls in the cycle right after the driver was enabled.
- R8: Chip enable never rises in the same cycle as write enable. A write always has one hold cycle with chip enable low and write enable high.
- R9: While valid is low, changes on the write flag, address and write data cause no strobe activity, and ready stays high.
- R10: A read returns the value most recently written to the same address. Writing one address leaves other addresses unchanged.
- R11: An asynchronous reset during a transfer returns every strobe to the deselected state and releases the data driver at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 12 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Value to drive on the shared data bus |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 4 | Value sampled from the shared data bus |

## Verification
The transfers used are chosen to separate distinct faults:
- Writes and reads at the lowest address, the highest address, a middle address and a pair of neighbouring addresses, with all-zero, all-one and alternating data. These show that the full address and data widths are wired through and that one address does not alias another.
- An overwrite followed by a read-back, and a read of an address never written. These tell a true read apart from stale data left in the capture register.
- A read that follows a write directly, and the reverse. These test the bus turnaround in both directions.
- A memory model whose data only becomes valid after the access time has run. It exposes a capture taken one cycle early.
- A reset in the middle of a write, and input changes while valid is low. These show the strobes returning to, or staying in, the deselected state.

// File: rtl/sram_seq.sv
module sram_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4,
  parameter int T_ADDR = 1,
  parameter int T_WP   = 2,
  parameter int T_ACC  = 2,
  parameter int T_TURN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int TMAX_AW = (T_ADDR > T_WP) ? T_ADDR : T_WP;
  localparam int TMAX_RT = (T_ACC > T_TURN) ? T_ACC : T_TURN;
  localparam int TMAX    = (TMAX_AW > TMAX_RT) ? TMAX_AW : TMAX_RT;
  localparam int CW      = (TMAX > 1) ? $clog2(TMAX) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_WRITE, S_READ, S_HOLD, S_TURN
  } state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic              is_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr   <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= CW'(T_ADDR - 1);
          st      <= S_SETUP;
        end
        S_SETUP: if (last) begin
          st  <= is_wr ? S_WRITE : S_READ;
          cnt <= is_wr ? CW'(T_WP - 1) : CW'(T_ACC - 1);
        end else cnt <= cnt - 1'b1;
        S_WRITE: if (last) st <= S_HOLD;
                 else cnt <= cnt - 1'b1;
        S_READ: if (last) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          st        <= S_HOLD;
        end else cnt <= cnt - 1'b1;
        S_HOLD: begin
          cnt <= CW'(T_TURN - 1);
          st  <= S_TURN;
        end
        S_TURN: if (last) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign mem_ce_n   = (st == S_IDLE) || (st == S_TURN);
  assign mem_we_n   = (st != S_WRITE);
  assign mem_oe_n   = (st != S_READ);
  assign mem_dq_oe  = is_wr && ((st == S_SETUP) || (st == S_WRITE) || (st == S_HOLD));
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_we_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_rsp_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  assert_ce_after_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n));

endmodule

// File: tb/sram_seq_tb.sv
`timescale 1ns/1ps
module sram_seq_tb;
  localparam int TA = 1, TW = 2, TR = 2, TT = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0]  rsp_rdata, mem_dq_out;
  logic [3:0]  mem_dq_in = '0;
  logic [11:0] mem_addr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_seq #(.ADDR_W(12), .DATA_W(4), .T_ADDR(TA), .T_WP(TW), .T_ACC(TR), .T_TURN(TT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: unwritten words read as 0; read data valid only after TR cycles of output enable low
  logic [3:0] mdl [logic [11:0]];
  bit prev_wr = 0, prev_ce_low = 0;
  logic [11:0] prev_addr = '0;
  logic [3:0] prev_data = '0;
  int oe_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_wr = 0; prev_ce_low = 0; oe_cnt = 0; mem_dq_in <= '0;
    end else begin
      logic drive;
      logic [3:0] word;
      drive = !mem_ce_n && mem_we_n && !mem_oe_n;
      if (drive && mem_dq_oe) check(0, "R7 bus contention", 1, 0);
      if (!mem_we_n && mem_ce_n) check(0, "R4 write strobe outside chip enable", 1, 0);
      if (!mem_we_n && !mem_dq_oe) check(0, "R5 data not driven during write pulse", 0, 1);
      if (prev_wr && (mem_we_n || mem_ce_n)) begin
        mdl[prev_addr] = prev_data;
        if (mem_ce_n) check(0, "R8 chip enable rose with write enable", 1, 0);
        if (!mem_dq_oe) check(0, "R5 no data hold after write", 0, 1);
      end
      if (!mem_ce_n && prev_ce_low && mem_addr != prev_addr)
        check(0, "R3 address moved under chip enable", mem_addr, prev_addr);
      prev_wr = !mem_ce_n && !mem_we_n;
      prev_ce_low = !mem_ce_n;
      prev_addr = mem_addr;
      prev_data = mem_dq_out;
      oe_cnt = drive ? oe_cnt + 1 : 0;
      word = mdl.exists(mem_addr) ? mdl[mem_addr] : 4'h0;
      mem_dq_in <= drive ? ((oe_cnt >= TR) ? word : ~word) : 4'h0;
    end
  end

  // Runs one transfer from a negedge, tracing strobes each cycle against the phase plan
  task automatic xfer(input bit w, input logic [11:0] a, input logic [3:0] d, input logic [3:0] exp);
    int k = 0, nrsp = 0, mid, busy;
    bit strobe_ok = 1, drv_ok = 1;
    logic [3:0] got = '0;
    mid = w ? TW : TR;
    busy = TA + mid + 1 + TT;
    req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a; req_wdata = ~d;
    while (!req_ready && k < 100) begin
      logic ece, ewe, eoe, edq;
      if (k < TA) begin ece = 0; ewe = 1; eoe = 1; edq = w; end
      else if (k < TA + mid) begin ece = 0; ewe = !w; eoe = w; edq = w; end
      else if (k == TA + mid) begin ece = 0; ewe = 1; eoe = 1; edq = w; end
      else begin ece = 1; ewe = 1; eoe = 1; edq = 0; end
      if (mem_ce_n != ece || mem_we_n != ewe || mem_oe_n != eoe) strobe_ok = 0;
      if (!ece && mem_addr != a) strobe_ok = 0;
      if (mem_dq_oe != edq || (edq && mem_dq_out != d)) drv_ok = 0;
      if (rsp_valid) begin nrsp++; got = rsp_rdata; end
      k++;
      @(negedge clk);
    end
    check(k == busy, "R2 busy cycle count", k, busy);
    check(strobe_ok, w ? "R4 write strobe sequence" : "R6 read strobe sequence", strobe_ok, 1);
    check(drv_ok, "R5 data driver window", drv_ok, 1);
    if (w) check(nrsp == 0, "R6 no response on write", nrsp, 0);
    else begin
      check(nrsp == 1, "R6 single response pulse", nrsp, 1);
      check(got == exp, "R10 read data", got, exp);
    end
  endtask

  // {write, addr, wdata, expected read}
  localparam logic [20:0] VEC [12] = '{
    {1'b1, 12'h000, 4'h5, 4'h0}, {1'b1, 12'hFFF, 4'hA, 4'h0},
    {1'b0, 12'h000, 4'h0, 4'h5}, {1'b0, 12'hFFF, 4'h0, 4'hA},
    {1'b1, 12'h001, 4'hF, 4'h0}, {1'b0, 12'h001, 4'h0, 4'hF},
    {1'b0, 12'h000, 4'h0, 4'h5}, {1'b1, 12'h000, 4'h0, 4'h0},
    {1'b0, 12'h000, 4'h0, 4'h0}, {1'b1, 12'h800, 4'hC, 4'h0},
    {1'b0, 12'h800, 4'h0, 4'hC}, {1'b0, 12'h7FF, 4'h0, 4'h0}
  };

  initial begin
    #200000;
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && req_ready && !mem_dq_oe, "R1 idle after reset", {mem_ce_n, req_ready, mem_dq_oe}, 3'b110);

    for (int i = 0; i < 12; i++)
      xfer(VEC[i][20], VEC[i][19:8], VEC[i][7:4], VEC[i][3:0]);

    begin
      bit quiet = 1;
      for (int i = 0; i < 6; i++) begin
        req_write = i[0]; req_addr = 12'h100 + 12'(i); req_wdata = 4'(i);
        @(negedge clk);
        if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe || !req_ready) quiet = 0;
      end
      check(quiet, "R9 no activity without valid", quiet, 1);
    end

    xfer(1'b1, 12'h3C0, 4'h6, 4'h0);
    xfer(1'b0, 12'h3C0, 4'h0, 4'h6);

    req_write = 1'b1; req_addr = 12'h2A5; req_wdata = 4'h9; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(!mem_we_n, "R11 write pulse in progress before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
          "R11 reset mid-transfer", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(1'b0, 12'h3C0, 4'h0, 4'h6);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule